// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Wakeup and Oldest-Ready Select

This block holds decoded instructions between an in-order front end and the functional units of a single-issue out-of-order core. Each cycle the front end may write one instruction at the tail of a circular buffer. The instruction carries an opcode (add, add-immediate or multiply), an immediate, an optional destination register and up to two optional source registers. For every used source the front end also says whether the producer is still in flight. That busy flag becomes the entry's per-source pending bit.

Two result-tag broadcast ports are provided, one fed by the integer unit and one fed by the multiplier. Each port compares its tag against every stored source and clears the pending bits that match. The compare result also feeds readiness in the same cycle, so a consumer can issue on the very edge at which its producer's tag is broadcast. The broadcast can therefore be driven ahead of writeback to allow back-to-back issue through bypassing.

Select picks the oldest ready entry, with age counted from the head pointer. Two hold inputs give the structural hazards: one for the integer unit and one for the multiplier. The chosen entry leaves the queue from whatever slot it sits in, and its fields appear on registered outputs one edge later.

Top module: `oo_issue_queue`

## Requirements
- R1: After reset the queue holds no entries, `out_valid` is 0 and `q_full` is 0.
- R2: An entry whose used sources are not busy, and whose unit is not held, issues on the edge after the edge that stored it. `out_valid` is 1 for one cycle and the outputs carry the stored opcode, immediate, destination and sources. Opcode codes are 0 add, 1 add-immediate and 2 multiply.
- R3: A pending source blocks issue until a broadcast on either port carries a tag equal to that source's register. The entry may issue on the same edge at which the matching broadcast is sampled.
- R4: A source whose use flag is 0 never blocks issue, whatever its busy flag or register number.
- R5: When several entries are ready, the one written earliest issues first. This order holds across wrap-around of the circular buffer.
- R6: While `hold_int` is 1 no add or add-immediate issues. While `hold_mul` is 1 no multiply issues. A ready younger entry of the other class issues past a held older one.
- R7: If a broadcast tag matches a busy source of the instruction being written in that same cycle, the source is stored as not pending.
- R8: At most one entry issues per cycle, and each written entry issues exactly once.
- R9: `q_full` is 1 when the slot at the tail still holds a live entry. This is the case after `DEPTH` writes with no issue. A write presented while `q_full` is 1 is dropped and never issues.
- R10: A broadcast whose tag matches no pending source, or whose valid bit is 0, leaves every pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write an instruction this cycle |
| in_op | input | 2 | Opcode: 0 add, 1 add-immediate, 2 multiply |
| in_imm | input | IMM_W | Immediate value |
| in_dst_use | input | 1 | Destination register is used |
| in_dst | input | REG_W | Destination register number |
| in_a_use | input | 1 | First source is used |
| in_a | input | REG_W | First source register number |
| in_a_busy | input | 1 | First source producer still in flight |
| in_b_use | input | 1 | Second source is used |
| in_b | input | REG_W | Second source register number |
| in_b_busy | input | 1 | Second source producer still in flight |
| q_full | output | 1 | Tail slot is occupied; writes are dropped |
| wb_int_v | input | 1 | Integer-unit result tag broadcast valid |
| wb_int_tag | input | REG_W | Integer-unit result register |
| wb_mul_v | input | 1 | Multiplier result tag broadcast valid |
| wb_mul_tag | input | REG_W | Multiplier result register |
| hold_int | input | 1 | Integer unit cannot accept an instruction |
| hold_mul | input | 1 | Multiplier cannot accept an instruction |
| out_valid | output | 1 | An instruction was issued at the last edge |
| out_op | output | 2 | Issued opcode |
| out_imm | output | IMM_W | Issued immediate |
| out_dst_use | output | 1 | Issued destination used |
| out_dst | output | REG_W | Issued destination register |
| out_a_use | output | 1 | Issued first source used |
| out_a | output | REG_W | Issued first source register |
| out_b_use | output | 1 | Issued second source used |
| out_b | output | REG_W | Issued second source register |

## Verification
Wakeup is tried with a matching tag on each broadcast port, with a tag for another register, with a broadcast that lands in the same cycle as the write, and with a busy flag on an unused source. Together these separate a correct tag compare from one that ignores the port, the tag or the use flag. Select is tried with several ready entries under both hold inputs. This shows whether priority follows age or slot number, and whether a hold blocks only its own class. A run of `DEPTH` held writes followed by a dropped extra write, starting from a head that has already moved, checks the full boundary and age order across wrap-around.

// File: rtl/oo_iq_pkg.sv
package oo_iq_pkg;
  typedef enum logic [1:0] {
    OPC_ADD  = 2'd0,
    OPC_ADDI = 2'd1,
    OPC_MUL  = 2'd2
  } iq_op_e;

  function automatic logic op_is_mul(input logic [1:0] op);
    return op == OPC_MUL;
  endfunction
endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match #(
  parameter int REG_W = 5
) (
  input  logic             src_use,
  input  logic [REG_W-1:0] src_tag,
  input  logic             wk0_v,
  input  logic [REG_W-1:0] wk0_tag,
  input  logic             wk1_v,
  input  logic [REG_W-1:0] wk1_tag,
  output logic             hit
);
  // A used source is woken by either broadcast port carrying its register.
  assign hit = src_use && ((wk0_v && (wk0_tag == src_tag)) ||
                           (wk1_v && (wk1_tag == src_tag)));
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Rotating priority: the first requester at or after base wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      int p;
      p = int'(base) + k;
      if (p >= DEPTH) p = p - DEPTH;
      if (req[p]) begin
        found = 1'b1;
        idx   = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/iq_payload_ram.sv
module iq_payload_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // One write port, one registered read port: maps onto a simple dual-port RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/oo_issue_queue.sv
module oo_issue_queue
  import oo_iq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int REG_W = 5,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [IMM_W-1:0] in_imm,
  input  logic             in_dst_use,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_a_use,
  input  logic [REG_W-1:0] in_a,
  input  logic             in_a_busy,
  input  logic             in_b_use,
  input  logic [REG_W-1:0] in_b,
  input  logic             in_b_busy,
  output logic             q_full,
  input  logic             wb_int_v,
  input  logic [REG_W-1:0] wb_int_tag,
  input  logic             wb_mul_v,
  input  logic [REG_W-1:0] wb_mul_tag,
  input  logic             hold_int,
  input  logic             hold_mul,
  output logic             out_valid,
  output logic [1:0]       out_op,
  output logic [IMM_W-1:0] out_imm,
  output logic             out_dst_use,
  output logic [REG_W-1:0] out_dst,
  output logic             out_a_use,
  output logic [REG_W-1:0] out_a,
  output logic             out_b_use,
  output logic [REG_W-1:0] out_b
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PW    = 2 + IMM_W + 3 + 3 * REG_W;

  // Per-slot state kept in flops: what wakeup and select must see in parallel.
  logic [DEPTH-1:0] vld_q, vld_nx;
  logic [DEPTH-1:0] a_use_q, a_pend_q, b_use_q, b_pend_q;
  logic [REG_W-1:0] a_tag_q [DEPTH];
  logic [REG_W-1:0] b_tag_q [DEPTH];
  logic [1:0]       op_q    [DEPTH];

  logic [IDX_W-1:0] head_q, head_nx, tail_q, tail_nx;
  logic             full_q, out_valid_q;

  logic [DEPTH-1:0] a_hit, b_hit, rdy;
  logic             in_a_hit, in_b_hit;
  logic             accept, fire, head_found;
  logic [IDX_W-1:0] pick_idx, head_idx;
  logic [PW-1:0]    ram_wdata, ram_rdata;

  assign accept = in_valid && !full_q;

  // Wakeup compare for the instruction being written this cycle.
  iq_tag_match #(.REG_W(REG_W)) u_in_a_match (
    .src_use(in_a_use), .src_tag(in_a),
    .wk0_v(wb_int_v), .wk0_tag(wb_int_tag),
    .wk1_v(wb_mul_v), .wk1_tag(wb_mul_tag),
    .hit(in_a_hit)
  );
  iq_tag_match #(.REG_W(REG_W)) u_in_b_match (
    .src_use(in_b_use), .src_tag(in_b),
    .wk0_v(wb_int_v), .wk0_tag(wb_int_tag),
    .wk1_v(wb_mul_v), .wk1_tag(wb_mul_tag),
    .hit(in_b_hit)
  );

  // Wakeup compare and readiness for every stored slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    iq_tag_match #(.REG_W(REG_W)) u_a_match (
      .src_use(a_use_q[g]), .src_tag(a_tag_q[g]),
      .wk0_v(wb_int_v), .wk0_tag(wb_int_tag),
      .wk1_v(wb_mul_v), .wk1_tag(wb_mul_tag),
      .hit(a_hit[g])
    );
    iq_tag_match #(.REG_W(REG_W)) u_b_match (
      .src_use(b_use_q[g]), .src_tag(b_tag_q[g]),
      .wk0_v(wb_int_v), .wk0_tag(wb_int_tag),
      .wk1_v(wb_mul_v), .wk1_tag(wb_mul_tag),
      .hit(b_hit[g])
    );
    // A same-cycle hit counts as not pending so the consumer issues back to back.
    assign rdy[g] = vld_q[g]
                 && (!a_use_q[g] || !a_pend_q[g] || a_hit[g])
                 && (!b_use_q[g] || !b_pend_q[g] || b_hit[g])
                 && !(op_is_mul(op_q[g]) ? hold_mul : hold_int);
  end

  // Oldest ready entry, age measured from the head pointer.
  iq_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_select (
    .req(rdy), .base(head_q), .found(fire), .idx(pick_idx)
  );

  always_comb begin
    vld_nx = vld_q;
    if (fire)   vld_nx[pick_idx] = 1'b0;
    if (accept) vld_nx[tail_q]   = 1'b1;
  end

  assign tail_nx = !accept ? tail_q
                 : (tail_q == IDX_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;

  // Head skips freed holes up to the oldest live entry, or meets the tail when empty.
  iq_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_head_seek (
    .req(vld_nx), .base(head_q), .found(head_found), .idx(head_idx)
  );
  assign head_nx = head_found ? head_idx : tail_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q       <= '0;
      a_pend_q    <= '0;
      b_pend_q    <= '0;
      a_use_q     <= '0;
      b_use_q     <= '0;
      head_q      <= '0;
      tail_q      <= '0;
      full_q      <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      vld_q       <= vld_nx;
      head_q      <= head_nx;
      tail_q      <= tail_nx;
      full_q      <= vld_nx[tail_nx];
      out_valid_q <= fire;
      for (int i = 0; i < DEPTH; i++) begin
        if (accept && tail_q == IDX_W'(i)) begin
          op_q[i]     <= in_op;
          a_use_q[i]  <= in_a_use;
          a_tag_q[i]  <= in_a;
          a_pend_q[i] <= in_a_use && in_a_busy && !in_a_hit;
          b_use_q[i]  <= in_b_use;
          b_tag_q[i]  <= in_b;
          b_pend_q[i] <= in_b_use && in_b_busy && !in_b_hit;
        end else begin
          if (a_hit[i]) a_pend_q[i] <= 1'b0;
          if (b_hit[i]) b_pend_q[i] <= 1'b0;
        end
      end
    end
  end

  // Full payload lives in a RAM, read at the selected slot into the output register.
  assign ram_wdata = {in_op, in_imm, in_dst_use, in_dst, in_a_use, in_a, in_b_use, in_b};

  iq_payload_ram #(.DEPTH(DEPTH), .WIDTH(PW), .IDX_W(IDX_W)) u_payload (
    .clk(clk), .we(accept), .waddr(tail_q), .wdata(ram_wdata),
    .re(fire), .raddr(pick_idx), .rdata(ram_rdata)
  );

  assign {out_op, out_imm, out_dst_use, out_dst, out_a_use, out_a, out_b_use, out_b} = ram_rdata;
  assign out_valid = out_valid_q;
  assign q_full    = full_q;

  AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full_q) |=> $stable(tail_q)); // R9
  AST_FULL_MEANS_TAIL_LIVE: assert property (@(posedge clk) disable iff (rst)
    full_q |-> vld_q[tail_q]); // R9
  AST_ISSUED_SLOT_FREED: assert property (@(posedge clk) disable iff (rst)
    fire |=> !vld_q[$past(pick_idx)]); // R8
  AST_MUL_HOLD_OBEYED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_is_mul(out_op)) |-> !$past(hold_mul)); // R6
  AST_INT_HOLD_OBEYED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !op_is_mul(out_op)) |-> !$past(hold_int)); // R6
endmodule

// File: tb/oo_issue_queue_bench.sv
module oo_issue_queue_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 8;
  localparam int REG_W = 5;
  localparam int IMM_W = 16;
  localparam logic [1:0] ADD = 2'd0, ADDI = 2'd1, MUL = 2'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_dst_use = 0, in_a_use = 0, in_a_busy = 0, in_b_use = 0, in_b_busy = 0;
  logic [1:0] in_op = '0;
  logic [IMM_W-1:0] in_imm = '0;
  logic [REG_W-1:0] in_dst = '0, in_a = '0, in_b = '0;
  logic wb_int_v = 0, wb_mul_v = 0, hold_int = 0, hold_mul = 0;
  logic [REG_W-1:0] wb_int_tag = '0, wb_mul_tag = '0;
  logic q_full, out_valid, out_dst_use, out_a_use, out_b_use;
  logic [1:0] out_op;
  logic [IMM_W-1:0] out_imm;
  logic [REG_W-1:0] out_dst, out_a, out_b;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  oo_issue_queue #(.DEPTH(DEPTH), .REG_W(REG_W), .IMM_W(IMM_W)) u_oo_issue_queue (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_op(in_op), .in_imm(in_imm),
    .in_dst_use(in_dst_use), .in_dst(in_dst),
    .in_a_use(in_a_use), .in_a(in_a), .in_a_busy(in_a_busy),
    .in_b_use(in_b_use), .in_b(in_b), .in_b_busy(in_b_busy),
    .q_full(q_full),
    .wb_int_v(wb_int_v), .wb_int_tag(wb_int_tag),
    .wb_mul_v(wb_mul_v), .wb_mul_tag(wb_mul_tag),
    .hold_int(hold_int), .hold_mul(hold_mul),
    .out_valid(out_valid), .out_op(out_op), .out_imm(out_imm),
    .out_dst_use(out_dst_use), .out_dst(out_dst),
    .out_a_use(out_a_use), .out_a(out_a),
    .out_b_use(out_b_use), .out_b(out_b)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic see_issue(input string req, input logic [1:0] op, input logic [IMM_W-1:0] imm);
    chk(out_valid === 1'b1, req, out_valid, 1);
    if (out_valid === 1'b1) begin
      chk(out_imm === imm, req, out_imm, imm);
      chk(out_op === op, req, out_op, op);
    end
  endtask

  task automatic see_none(input string req);
    chk(out_valid === 1'b0, req, out_valid, 0);
  endtask

  // Called at a negedge; returns at the next negedge, after the storing edge.
  task automatic put(input logic [1:0] op, input logic [IMM_W-1:0] imm,
                     input logic [REG_W-1:0] dst,
                     input logic au, input logic [REG_W-1:0] a, input logic ab,
                     input logic bu, input logic [REG_W-1:0] b, input logic bb);
    in_valid = 1; in_op = op; in_imm = imm; in_dst_use = 1; in_dst = dst;
    in_a_use = au; in_a = a; in_a_busy = ab;
    in_b_use = bu; in_b = b; in_b_busy = bb;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset;
    see_none("R1 out_valid after reset");
    chk(q_full === 1'b0, "R1 q_full after reset", q_full, 0);
  endtask

  task automatic t_basic;
    put(ADD, 16'h1234, 5'd3, 1, 5'd1, 0, 1, 5'd2, 0);
    see_none("R2 no issue on storing edge");
    @(negedge clk);
    see_issue("R2 ready entry issues", ADD, 16'h1234);
    chk(out_dst === 5'd3 && out_a === 5'd1 && out_b === 5'd2, "R2 payload registers",
        {out_dst, out_a, out_b}, {5'd3, 5'd1, 5'd2});
    @(negedge clk);
    see_none("R8 entry issues only once");
  endtask

  task automatic t_wake;
    put(MUL, 16'h2001, 5'd7, 1, 5'd5, 1, 1, 5'd6, 0);
    wb_mul_v = 1; wb_mul_tag = 5'd9;
    @(negedge clk);
    wb_mul_v = 0;
    see_none("R10 non-matching tag leaves pending");
    wb_int_v = 0; wb_int_tag = 5'd5;
    @(negedge clk);
    see_none("R10 invalid broadcast leaves pending");
    wb_int_v = 1; wb_int_tag = 5'd5;
    @(negedge clk);
    wb_int_v = 0;
    see_issue("R3 issue on same edge as integer-port wakeup", MUL, 16'h2001);
    put(ADDI, 16'h2002, 5'd8, 0, 5'd0, 0, 1, 5'd11, 1);
    see_none("R3 pending second source holds");
    wb_mul_v = 1; wb_mul_tag = 5'd11;
    @(negedge clk);
    wb_mul_v = 0;
    see_issue("R3 issue after multiplier-port wakeup", ADDI, 16'h2002);
  endtask

  task automatic t_unused;
    put(ADDI, 16'h3003, 5'd4, 0, 5'd9, 1, 0, 5'd10, 1);
    @(negedge clk);
    see_issue("R4 unused busy sources ignored", ADDI, 16'h3003);
  endtask

  task automatic t_same_cycle;
    wb_int_v = 1; wb_int_tag = 5'd12;
    put(ADD, 16'h4004, 5'd1, 1, 5'd12, 1, 0, 5'd0, 0);
    wb_int_v = 0;
    @(negedge clk);
    see_issue("R7 same-cycle wakeup clears pending at write", ADD, 16'h4004);
    wb_int_v = 1; wb_int_tag = 5'd14;
    put(ADD, 16'h4005, 5'd1, 1, 5'd13, 1, 0, 5'd0, 0);
    wb_int_v = 0;
    @(negedge clk);
    see_none("R10 same-cycle other tag keeps pending");
    wb_mul_v = 1; wb_mul_tag = 5'd13;
    @(negedge clk);
    wb_mul_v = 0;
    see_issue("R3 late wakeup releases entry", ADD, 16'h4005);
  endtask

  task automatic t_order;
    hold_int = 1;
    put(ADD, 16'h00A1, 5'd1, 0, 5'd0, 0, 0, 5'd0, 0);
    put(ADDI, 16'h00A2, 5'd2, 0, 5'd0, 0, 0, 5'd0, 0);
    put(ADD, 16'h00A3, 5'd3, 0, 5'd0, 0, 0, 5'd0, 0);
    see_none("R6 held integer entries do not issue");
    hold_int = 0;
    @(negedge clk);
    see_issue("R5 oldest first", ADD, 16'h00A1);
    @(negedge clk);
    see_issue("R5 second oldest", ADDI, 16'h00A2);
    @(negedge clk);
    see_issue("R5 youngest last", ADD, 16'h00A3);
    @(negedge clk);
    see_none("R8 no extra issue");
  endtask

  task automatic t_hazard;
    hold_int = 1; hold_mul = 1;
    put(ADD, 16'h00B1, 5'd1, 0, 5'd0, 0, 0, 5'd0, 0);
    put(MUL, 16'h00B2, 5'd2, 0, 5'd0, 0, 0, 5'd0, 0);
    @(negedge clk);
    see_none("R6 both units held");
    hold_mul = 0;
    @(negedge clk);
    see_issue("R6 younger multiply passes held add", MUL, 16'h00B2);
    hold_int = 0;
    @(negedge clk);
    see_issue("R6 add issues after release", ADD, 16'h00B1);
  endtask

  task automatic t_full;
    int seen;
    bit order_ok;
    bit dropped_seen;
    hold_int = 1;
    for (int k = 0; k < DEPTH; k++) begin
      put(ADD, 16'h00C0 + 16'(k), 5'd1, 0, 5'd0, 0, 0, 5'd0, 0);
      if (k == DEPTH - 2) chk(q_full === 1'b0, "R9 not full one slot short", q_full, 0);
    end
    chk(q_full === 1'b1, "R9 full after DEPTH writes", q_full, 1);
    put(ADD, 16'h00EE, 5'd1, 0, 5'd0, 0, 0, 5'd0, 0);
    chk(q_full === 1'b1, "R9 still full after dropped write", q_full, 1);
    hold_int = 0;
    seen = 0; order_ok = 1; dropped_seen = 0;
    for (int c = 0; c < DEPTH + 4; c++) begin
      @(negedge clk);
      if (out_valid === 1'b1) begin
        if (out_imm == 16'h00EE) dropped_seen = 1;
        else if (out_imm != 16'h00C0 + 16'(seen)) order_ok = 0;
        seen++;
      end
    end
    chk(seen == DEPTH, "R9 exactly DEPTH entries drain", seen, DEPTH);
    chk(!dropped_seen, "R9 dropped write never issues", dropped_seen, 0);
    chk(order_ok, "R5 age order across wrap", order_ok, 1);
    chk(q_full === 1'b0, "R9 full clears after drain", q_full, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wake();
    t_unused();
    t_same_cycle();
    t_order();
    t_hazard();
    t_full();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule